// File: doc/BRIEF.md
# Watchdog and Brownout Reset Supervisor

This block produces the chip's internal reset request from two independent causes. A free-running timeout counter on the main oscillator clock must be cleared by software at regular intervals; if it is left alone for a full counter period, it requests a reset. A low-voltage comparator output is also watched. When it reports a supply dip, the block records the cause in a sticky status flag and requests a reset.

Both causes drive one fixed-length reset pulse. The timeout counter also reacts to the device's power modes. Entering sleep, timer or hold mode, or losing the oscillator, keeps it at zero. Stop mode freezes it at its current value. The supply monitor keeps working in stop mode, so its reset pulse can bring the part out of that mode.

Software sees a two-bit control word. Bit 0 is the watchdog clear bit and bit 1 is the low-voltage flag. A single write carries both fields, so software writes 1 to any field it does not want to change.

Top module: `rst_supervisor`

## Requirements
- R1: With no clearing event, `int_rst` rises exactly 2^WDOG_BITS clock edges after the last edge on which the counter was cleared.
- R2: After `por` is released, the watchdog counts with no enable write. The first timeout reset follows 2^WDOG_BITS edges after the last `por` edge.
- R3: Writing a word with bit 0 = 0 clears the watchdog counter. Writing bit 0 = 1 leaves the counter unchanged. Bit 0 of `reg_rdata` always reads 1.
- R4: While any of `osc_stopped`, `sleep_mode`, `timer_mode` or `hold_req` is high, the counter is held at zero. Counting restarts from zero on the first edge after the input drops.
- R5: The counter is held at zero while `int_rst` is high, so a new full period starts when the pulse ends.
- R6: While `stop_mode` is high and no clear source is active, the counter keeps its value. It resumes from that value afterwards.
- R7: `lv_detect` passes through a two-stage synchronizer. A high level sampled on edge k sets `reg_rdata` bit 1 and raises `int_rst` after edge k+2, provided no pulse is active.
- R8: Low-voltage detection and its reset pulse work while `stop_mode` is high.
- R9: Each `int_rst` pulse lasts exactly PULSE_LEN cycles. A trigger from either source during a pulse neither lengthens it nor starts a second pulse.
- R10: The low-voltage flag survives `int_rst`. A write with bit 1 = 0 clears it and a write with bit 1 = 1 leaves it alone. If a detection and a clear happen in the same cycle, the detection wins.
- R11: `por` is a synchronous active-high reset. After it, `int_rst` = 0 and `reg_rdata` = 2'b01.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Main oscillator clock |
| por | input | 1 | Power-on reset, synchronous, active high |
| lv_detect | input | 1 | Low-voltage comparator output, asynchronous |
| stop_mode | input | 1 | Device is in stop mode |
| sleep_mode | input | 1 | Device is in sleep mode |
| timer_mode | input | 1 | Device is in time-base or timer mode |
| hold_req | input | 1 | Bus hold is active |
| osc_stopped | input | 1 | Main oscillator is stopped |
| reg_wr | input | 1 | Control word write strobe |
| reg_wdata | input | 2 | Write data: bit 0 watchdog clear, bit 1 low-voltage flag |
| reg_rdata | output | 2 | Read data: bit 0 constant 1, bit 1 low-voltage flag |
| int_rst | output | 1 | Internal reset pulse, active high |

## Verification
Some properties hold on every cycle, and the assertions check these. Pulse length is never more than PULSE_LEN and always exactly PULSE_LEN when a pulse ends. A synchronized low-voltage level always starts a pulse when none is active, and the flag is then set. No timeout trigger appears while a clear source or stop mode is active. The flag is never lost without a clearing write, and a trigger during a pulse always lets the pulse run down.

Other behaviour needs a chosen history, so only the bench scenarios show it. These include the exact timeout edge counted from por, a write or a mode clear, and resuming from a frozen count after stop. They also cover the write-1 no-effect cases and the interplay of detection with flag clears.

// File: rtl/rstsup_pkg.sv
package rstsup_pkg;

    // Control word layout; bit positions are visible to software.
    typedef struct packed {
        logic lv_flag;   // bit 1
        logic wd_kick;   // bit 0
    } ctrl_word_t;

    typedef struct packed {
        logic stop;
        logic sleep;
        logic timer;
        logic hold;
        logic osc_off;
    } pwr_mode_t;

    typedef enum logic [1:0] {
        WD_COUNT  = 2'd0,
        WD_CLEAR  = 2'd1,
        WD_FREEZE = 2'd2
    } wd_action_t;

    // Clearing causes beat the stop freeze; counting is the default.
    function automatic wd_action_t wd_decide(pwr_mode_t m, logic kick, logic int_rst);
        if (kick || int_rst || m.osc_off || m.sleep || m.timer || m.hold)
            return WD_CLEAR;
        else if (m.stop)
            return WD_FREEZE;
        return WD_COUNT;
    endfunction

endpackage

// File: rtl/rstsup_wdog.sv
module rstsup_wdog
    import rstsup_pkg::*;
#(
    parameter int WDOG_BITS = 20
) (
    input  logic      clk,
    input  logic      por,
    input  pwr_mode_t mode,
    input  logic      kick,
    input  logic      int_rst,
    output logic      fire
);

    localparam logic [WDOG_BITS-1:0] LAST = '1;
    localparam logic [WDOG_BITS-1:0] ONE  = WDOG_BITS'(1);

    logic [WDOG_BITS-1:0] cnt_q;
    wd_action_t           act;

    always_comb act = wd_decide(mode, kick, int_rst);

    always_ff @(posedge clk) begin
        if (por) begin
            cnt_q <= '0;
        end else begin
            case (act)
                WD_CLEAR:  cnt_q <= '0;
                WD_FREEZE: cnt_q <= cnt_q;
                default:   cnt_q <= cnt_q + ONE;
            endcase
        end
    end

    // Timeout when the final count value is reached while counting.
    assign fire = (act == WD_COUNT) && (cnt_q == LAST);

    // R4: no timeout while a clearing cause is present
    a_r4_clear_blocks_fire: assert property (@(posedge clk) disable iff (por)
        (kick || int_rst || mode.osc_off || mode.sleep || mode.timer || mode.hold) |-> !fire);

    // R6: a frozen counter never times out
    a_r6_stop_blocks_fire: assert property (@(posedge clk) disable iff (por)
        mode.stop |-> !fire);

endmodule

// File: rtl/rstsup_lvmon.sv
module rstsup_lvmon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic por,
    input  logic lv_raw,
    input  logic flag_wr,
    input  logic flag_wdata,
    output logic lv_level,
    output logic lv_flag
);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   flag_q;

    always_ff @(posedge clk) begin
        if (por) begin
            sync_q <= '0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], lv_raw};
        end
    end

    assign lv_level = sync_q[SYNC_STAGES-1];

    // Detection has priority over a software clear in the same cycle.
    always_ff @(posedge clk) begin
        if (por) begin
            flag_q <= 1'b0;
        end else if (lv_level) begin
            flag_q <= 1'b1;
        end else if (flag_wr && !flag_wdata) begin
            flag_q <= 1'b0;
        end
    end

    assign lv_flag = flag_q;

    // R10: flag is kept unless software writes 0
    a_r10_flag_sticky: assert property (@(posedge clk) disable iff (por)
        (lv_flag && !(flag_wr && !flag_wdata)) |=> lv_flag);

    // R7: a synchronized detection always sets the flag
    a_r7_flag_set: assert property (@(posedge clk) disable iff (por)
        lv_level |=> lv_flag);

endmodule

// File: rtl/rstsup_pulse.sv
module rstsup_pulse #(
    parameter int PULSE_LEN = 16,
    parameter int NSRC      = 2
) (
    input  logic            clk,
    input  logic            por,
    input  logic [NSRC-1:0] trig,
    output logic            active
);

    localparam int            CW    = $clog2(PULSE_LEN + 1);
    localparam logic [CW-1:0] LEN_C = CW'(PULSE_LEN);
    localparam logic [CW-1:0] ONE   = CW'(1);

    logic [CW-1:0] left_q;

    // A running pulse ignores new triggers; only an idle one loads.
    always_ff @(posedge clk) begin
        if (por) begin
            left_q <= '0;
        end else if (left_q != '0) begin
            left_q <= left_q - ONE;
        end else if (|trig) begin
            left_q <= LEN_C;
        end
    end

    assign active = (left_q != '0);

    // R9: a trigger during a pulse never reloads the remaining length
    a_r9_no_extend: assert property (@(posedge clk) disable iff (por)
        (active && (|trig)) |=> (left_q < $past(left_q)));

endmodule

// File: rtl/rst_supervisor.sv
module rst_supervisor
    import rstsup_pkg::*;
#(
    parameter int WDOG_BITS   = 20,
    parameter int PULSE_LEN   = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       por,
    input  logic       lv_detect,
    input  logic       stop_mode,
    input  logic       sleep_mode,
    input  logic       timer_mode,
    input  logic       hold_req,
    input  logic       osc_stopped,
    input  logic       reg_wr,
    input  logic [1:0] reg_wdata,
    output logic [1:0] reg_rdata,
    output logic       int_rst
);

    localparam int RW = $clog2(PULSE_LEN + 2);

    pwr_mode_t  mode;
    ctrl_word_t wr_word;
    ctrl_word_t rd_word;
    logic       kick;
    logic       wd_fire;
    logic       lv_level;
    logic       lv_flag;
    logic       pulse_on;

    always_comb begin
        mode.stop    = stop_mode;
        mode.sleep   = sleep_mode;
        mode.timer   = timer_mode;
        mode.hold    = hold_req;
        mode.osc_off = osc_stopped;
    end

    assign wr_word = ctrl_word_t'(reg_wdata);
    assign kick    = reg_wr && !wr_word.wd_kick;

    rstsup_wdog #(.WDOG_BITS(WDOG_BITS)) wdog_i (
        .clk     (clk),
        .por     (por),
        .mode    (mode),
        .kick    (kick),
        .int_rst (pulse_on),
        .fire    (wd_fire)
    );

    rstsup_lvmon #(.SYNC_STAGES(SYNC_STAGES)) lvmon_i (
        .clk        (clk),
        .por        (por),
        .lv_raw     (lv_detect),
        .flag_wr    (reg_wr),
        .flag_wdata (wr_word.lv_flag),
        .lv_level   (lv_level),
        .lv_flag    (lv_flag)
    );

    rstsup_pulse #(.PULSE_LEN(PULSE_LEN), .NSRC(2)) pulse_i (
        .clk    (clk),
        .por    (por),
        .trig   ({wd_fire, lv_level}),
        .active (pulse_on)
    );

    always_comb begin
        rd_word.lv_flag = lv_flag;
        rd_word.wd_kick = 1'b1;
    end

    assign reg_rdata = rd_word;
    assign int_rst   = pulse_on;

    // Length of the current high run, used only by the checks below.
    logic [RW-1:0] run_q;
    always_ff @(posedge clk) begin
        if (por) run_q <= '0;
        else     run_q <= int_rst ? run_q + RW'(1) : '0;
    end

    // R9: a pulse never runs longer than PULSE_LEN
    a_r9_len_cap: assert property (@(posedge clk) disable iff (por)
        int_rst |-> (int'(run_q) < PULSE_LEN));

    // R9: a pulse that ends on its own lasted exactly PULSE_LEN
    a_r9_len_exact: assert property (@(posedge clk) disable iff (por)
        (!$past(por) && $fell(int_rst)) |-> (int'(run_q) == PULSE_LEN));

    // R7: synchronized low voltage starts a pulse when idle
    a_r7_lv_starts_pulse: assert property (@(posedge clk) disable iff (por)
        (lv_level && !int_rst) |=> int_rst);

endmodule

// File: tb/rst_supervisor_tb_top.sv
module rst_supervisor_tb_top;

    localparam int WB = 6;
    localparam int PL = 16;
    localparam int PERIOD_EDGES = 1 << WB;

    logic       clk = 1'b0;
    logic       por = 1'b1;
    logic       lv_detect = 1'b0;
    logic       stop_mode = 1'b0;
    logic       sleep_mode = 1'b0;
    logic       timer_mode = 1'b0;
    logic       hold_req = 1'b0;
    logic       osc_stopped = 1'b0;
    logic       reg_wr = 1'b0;
    logic [1:0] reg_wdata = 2'b11;
    logic [1:0] reg_rdata;
    logic       int_rst;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    rst_supervisor #(.WDOG_BITS(WB), .PULSE_LEN(PL), .SYNC_STAGES(2)) dut_i (
        .clk         (clk),
        .por         (por),
        .lv_detect   (lv_detect),
        .stop_mode   (stop_mode),
        .sleep_mode  (sleep_mode),
        .timer_mode  (timer_mode),
        .hold_req    (hold_req),
        .osc_stopped (osc_stopped),
        .reg_wr      (reg_wr),
        .reg_wdata   (reg_wdata),
        .reg_rdata   (reg_rdata),
        .int_rst     (int_rst)
    );

    // Vector: {lv, wr, wdata[1:0], expected rdata[1:0]}
    localparam logic [5:0] VEC [6] = '{
        6'b0_1_11_01,
        6'b1_0_00_11,
        6'b0_1_11_11,
        6'b0_1_01_01,
        6'b1_1_01_11,
        6'b0_1_00_01
    };

    task automatic step(int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_por();
        por = 1'b1;
        lv_detect = 1'b0; stop_mode = 1'b0; sleep_mode = 1'b0; timer_mode = 1'b0;
        hold_req = 1'b0; osc_stopped = 1'b0; reg_wr = 1'b0; reg_wdata = 2'b11;
        step(2);
        por = 1'b0;
    endtask

    task automatic set_mode(int m, logic v);
        case (m)
            0: osc_stopped = v;
            1: sleep_mode  = v;
            2: timer_mode  = v;
            default: hold_req = v;
        endcase
    endtask

    initial begin
        int cyc = 0;
        while (!done && cyc < 150000) begin
            @(posedge clk);
            cyc++;
        end
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=%0d expected<150000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        do_por();
        // R11 reset state
        check("R11 int_rst after por", int_rst, 0);
        check("R11 rdata after por", reg_rdata, 2'b01);

        // R10 / R7: flag vectors
        for (int i = 0; i < 6; i++) begin
            lv_detect = VEC[i][5];
            reg_wr    = VEC[i][4];
            reg_wdata = VEC[i][3:2];
            step(1);
            lv_detect = 1'b0;
            reg_wr    = 1'b0;
            reg_wdata = 2'b11;
            step(2);
            check("R10 flag vector", reg_rdata, {30'd0, VEC[i][1:0]});
        end

        // R1/R2: timeout counted from por release
        do_por();
        step(PERIOD_EDGES - 1);
        check("R2 no reset before period", int_rst, 0);
        step(1);
        check("R1 timeout reset", int_rst, 1);
        // R9: fixed length, lv during pulse does not extend
        lv_detect = 1'b1;
        step(1);
        lv_detect = 1'b0;
        step(PL - 2);
        check("R9 pulse still high", int_rst, 1);
        step(1);
        check("R9 pulse ends at PULSE_LEN", int_rst, 0);
        step(2);
        check("R9 no second pulse", int_rst, 0);

        // R5: counter cleared during pulse
        do_por();
        step(PERIOD_EDGES + PL);
        check("R5 pulse over", int_rst, 0);
        step(PERIOD_EDGES - 1);
        check("R5 no early reset", int_rst, 0);
        step(1);
        check("R5 full period after pulse", int_rst, 1);

        // R3: write 0 to clear bit restarts counter
        do_por();
        step(50);
        reg_wr = 1'b1; reg_wdata = 2'b10;
        step(1);
        reg_wr = 1'b0; reg_wdata = 2'b11;
        step(PERIOD_EDGES - 1);
        check("R3 kick delays timeout", int_rst, 0);
        step(1);
        check("R3 timeout after kick", int_rst, 1);

        // R3: write 1 to clear bit has no effect; reads 1
        do_por();
        step(50);
        reg_wr = 1'b1; reg_wdata = 2'b11;
        step(1);
        reg_wr = 1'b0;
        check("R3 clear bit reads 1", reg_rdata[0], 1);
        step(PERIOD_EDGES - 52);
        check("R3 write 1 before timeout", int_rst, 0);
        step(1);
        check("R3 write 1 no effect", int_rst, 1);

        // R4: each mode holds the counter at zero
        for (int m = 0; m < 4; m++) begin
            do_por();
            step(40);
            set_mode(m, 1'b1);
            step(10);
            set_mode(m, 1'b0);
            step(PERIOD_EDGES - 1);
            check("R4 mode clear delays", int_rst, 0);
            step(1);
            check("R4 restart after mode", int_rst, 1);
        end

        // R6: stop freezes the count
        do_por();
        step(40);
        stop_mode = 1'b1;
        step(100);
        check("R6 no reset in stop", int_rst, 0);
        stop_mode = 1'b0;
        step(PERIOD_EDGES - 41);
        check("R6 resumes frozen count", int_rst, 0);
        step(1);
        check("R6 timeout after resume", int_rst, 1);

        // R8/R7: low voltage in stop, 2-stage sync timing
        do_por();
        stop_mode = 1'b1;
        lv_detect = 1'b1;
        step(1);
        lv_detect = 1'b0;
        step(1);
        check("R7 not before sync", int_rst, 0);
        step(1);
        check("R8 lv reset in stop", int_rst, 1);
        check("R7 flag set", reg_rdata, 2'b11);
        step(PL + 2);
        check("R10 flag survives reset", reg_rdata, 2'b11);
        stop_mode = 1'b0;
        do_por();
        check("R11 por clears flag", reg_rdata, 2'b01);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule